// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag GPIO Port

An 8-bit general-purpose I/O port. Each pin has its own output value, direction, interrupt enable, edge polarity and pending-flag bit. All of these sit behind a small synchronous register bus: address, write data and write enable, with combinational read data. Every pin is observed through a two-flop synchronizer. A selected transition on the observed value latches that pin's pending flag. One interrupt request line is raised while any enabled pin has a pending flag and the global interrupt enable input is high.

The value a pin is observed at is the value on the pad. For a pin configured as an output, that is the port's own driven value. For a pin configured as an input, it is the external input. As a result, writes to the output or direction registers can create a transition and latch a flag.

Software owns the flags. Hardware only ever sets them. A write to the flag register loads the written byte, so writing a 1 raises a software-initiated request and writing a 0 clears a pending flag. When a pin transition and a software write hit the same flag in the same cycle, the transition wins.

Top module: `gpio_edge_port`

## Requirements
- R1: A synchronous active-high reset clears the output, direction, enable, edge-select and flag registers to 0, so irq, pad_out and pad_oe are 0. The synchronizer history is loaded from the current pad value, so no flag is set after reset even when pins are held high.
- R2: With edge-select bit 0, a 0-to-1 change on a pin sets its flag. If the pin changes just after a falling clock edge, the flag reads 1 after the third rising clock edge and still reads 0 after the second. A 1-to-0 change does not set the flag.
- R3: With edge-select bit 1, a 1-to-0 change sets the flag and a 0-to-1 change does not.
- R4: A pin held at a constant level never sets its flag. After software clears the flag, it stays 0.
- R5: A write to the flag register loads the written byte: a 1 bit sets that flag and a 0 bit clears it. Hardware never clears a flag.
- R6: irq is 1 exactly when global_ie is 1 and at least one pin has both its flag and its enable bit set.
- R7: If a pin transition and a software write of 0 reach the same flag in the same cycle, the flag ends up set.
- R8: pad_out equals the output register and pad_oe equals the direction register. For a pin with direction 1, the input register reads back the driven output value, through the synchronizer.
- R9: A write to the output or direction register that changes a pin's observed value sets that pin's flag according to its edge select.
- R10: Register addresses are 0 input (read-only; writes are ignored), 1 output, 2 direction, 3 enable, 4 edge select, 5 flag. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 8 | Read data of the addressed register (combinational) |
| pad_in | input | 8 | External pin inputs |
| pad_out | output | 8 | Pin output values |
| pad_oe | output | 8 | Pin output enables (1 = pin is driven) |
| global_ie | input | 1 | Global interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
Pin patterns cover rising and falling transitions under each edge-select value, which tells a polarity error apart from a detect that fires on every change. A long constant level after a clear exposes level-sensitive detection. Timing is probed one cycle before and at the expected flag edge, which exposes a missing or extra synchronizer stage. Output and direction writes with the pad input held low show that the loopback path reaches the detector. A transition timed to meet a software clear in the same cycle separates set-wins priority from clear-wins.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;

    localparam int GPIO_ADDR_W = 3;

    typedef enum logic [GPIO_ADDR_W-1:0] {
        SEL_IN   = 3'd0,
        SEL_OUT  = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_IE   = 3'd3,
        SEL_EDGE = 3'd4,
        SEL_FLAG = 3'd5
    } reg_sel_e;

    // Transition of interest: fall=0 rising, fall=1 falling
    function automatic logic edge_hit(input logic prev, input logic cur, input logic fall);
        return fall ? (prev & ~cur) : (~prev & cur);
    endfunction

endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= d;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_detect.sv
`timescale 1ns/1ps
module gpio_edge_detect
    import gpio_edge_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] fall_sel,
    output logic [W-1:0] hit
);
    logic [W-1:0] hist;

    always_ff @(posedge clk) begin
        hist <= cur;
    end

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign hit[i] = edge_hit(hist[i], cur[i], fall_sel[i]);
    end

    // A steady observed value must not report a transition
    assert_level_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        $stable(cur) |-> (hit == '0));
endmodule

// File: rtl/gpio_flag_reg.sv
`timescale 1ns/1ps
module gpio_flag_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_we,
    input  logic [W-1:0] sw_data,
    input  logic [W-1:0] hw_set,
    output logic [W-1:0] flag
);
    logic [W-1:0] base;

    always_comb begin
        base = sw_we ? sw_data : flag;
    end

    always_ff @(posedge clk) begin
        if (rst) flag <= '0;
        else     flag <= base | hw_set;
    end

    assert_hw_never_clears_R5: assert property (@(posedge clk) disable iff (rst)
        !sw_we |=> ((flag & $past(flag)) == $past(flag)));

    assert_sw_write_loads_R5: assert property (@(posedge clk) disable iff (rst)
        (sw_we && hw_set == '0) |=> (flag == $past(sw_data)));

    assert_edge_sets_flag_R2: assert property (@(posedge clk) disable iff (rst)
        (hw_set != '0) |=> ((flag & $past(hw_set)) == $past(hw_set)));

    assert_set_beats_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (sw_we && hw_set != '0) |=> ((flag & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/gpio_edge_port.sv
`timescale 1ns/1ps
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [GPIO_ADDR_W-1:0] bus_addr,
    input  logic [NUM_PINS-1:0]    bus_wdata,
    input  logic                   bus_we,
    output logic [NUM_PINS-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0]    pad_in,
    output logic [NUM_PINS-1:0]    pad_out,
    output logic [NUM_PINS-1:0]    pad_oe,
    input  logic                   global_ie,
    output logic                   irq
);
    reg_sel_e            sel;
    logic [NUM_PINS-1:0] out_q, dir_q, ie_q, fall_q;
    logic [NUM_PINS-1:0] pad_seen, pin_sync, pin_hit, flag_q;
    logic                flag_we;

    assign sel     = reg_sel_e'(bus_addr);
    assign flag_we = bus_we && (sel == SEL_FLAG);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            dir_q  <= '0;
            ie_q   <= '0;
            fall_q <= '0;
        end else if (bus_we) begin
            case (sel)
                SEL_OUT:  out_q  <= bus_wdata;
                SEL_DIR:  dir_q  <= bus_wdata;
                SEL_IE:   ie_q   <= bus_wdata;
                SEL_EDGE: fall_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // Pad model: a driven pin shows its own output value
    assign pad_out  = out_q;
    assign pad_oe   = dir_q;
    assign pad_seen = (dir_q & out_q) | (~dir_q & pad_in);

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_seen),
        .q   (pin_sync)
    );

    gpio_edge_detect #(.W(NUM_PINS)) u_detect (
        .clk      (clk),
        .rst      (rst),
        .cur      (pin_sync),
        .fall_sel (fall_q),
        .hit      (pin_hit)
    );

    gpio_flag_reg #(.W(NUM_PINS)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .sw_we   (flag_we),
        .sw_data (bus_wdata),
        .hw_set  (pin_hit),
        .flag    (flag_q)
    );

    always_comb begin
        case (sel)
            SEL_IN:   bus_rdata = pin_sync;
            SEL_OUT:  bus_rdata = out_q;
            SEL_DIR:  bus_rdata = dir_q;
            SEL_IE:   bus_rdata = ie_q;
            SEL_EDGE: bus_rdata = fall_q;
            SEL_FLAG: bus_rdata = flag_q;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = global_ie & (|(flag_q & ie_q));

    assert_irq_needs_gie_R6: assert property (@(posedge clk) disable iff (rst)
        irq |-> (global_ie && ie_q != '0 && flag_q != '0));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (flag_q == '0 && pad_oe == '0));
endmodule

// File: tb/tb_gpio_edge_port.sv
`timescale 1ns/1ps
module tb_gpio_edge_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h0F;
    logic [7:0] pad_out, pad_oe;
    logic       global_ie = 1'b0;
    logic       irq;

    int checks = 0;
    int failures = 0;

    localparam logic [2:0] A_IN = 3'd0, A_OUT = 3'd1, A_DIR = 3'd2,
                           A_IE = 3'd3, A_EDGE = 3'd4, A_FLAG = 3'd5;

    always #10 clk = ~clk;

    gpio_edge_port dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .global_ie(global_ie), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // Read at the current time (called just after a falling edge)
    task automatic rd_now(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        @(negedge clk);
        rd_now(a, v);
        check(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R1 out", A_OUT, 8'h00);
        rd_check("R1 dir", A_DIR, 8'h00);
        rd_check("R1 ie", A_IE, 8'h00);
        rd_check("R1 edge", A_EDGE, 8'h00);
        rd_check("R1 flag", A_FLAG, 8'h00);
        check("R1 irq", {7'd0, irq}, 8'h00);
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        idle(4);
        rd_check("R1 no false edge", A_FLAG, 8'h00);
        rd_check("R10 input read", A_IN, 8'h0F);
    endtask

    task automatic t_rising();
        logic [7:0] v;
        @(negedge clk);
        pad_in = 8'h1F;
        @(negedge clk);
        @(negedge clk);
        rd_now(A_FLAG, v);
        check("R2 not before 3rd edge", v, 8'h00);
        @(negedge clk);
        rd_now(A_FLAG, v);
        check("R2 set at 3rd edge", v, 8'h10);
        @(negedge clk);
        pad_in = 8'h1E;
        idle(4);
        rd_check("R2 falling ignored", A_FLAG, 8'h10);
    endtask

    task automatic t_falling();
        wr(A_FLAG, 8'h00);
        wr(A_EDGE, 8'h01);
        pad_in = 8'h1F;
        idle(4);
        rd_check("R3 rising ignored", A_FLAG, 8'h00);
        pad_in = 8'h1E;
        idle(4);
        rd_check("R3 falling sets", A_FLAG, 8'h01);
        wr(A_EDGE, 8'h00);
        wr(A_FLAG, 8'h00);
    endtask

    task automatic t_level();
        idle(8);
        rd_check("R4 held level", A_FLAG, 8'h00);
    endtask

    task automatic t_sw();
        wr(A_FLAG, 8'hA0);
        rd_check("R5 sw set", A_FLAG, 8'hA0);
        wr(A_FLAG, 8'h20);
        rd_check("R5 sw clear", A_FLAG, 8'h20);
        idle(5);
        rd_check("R5 hw never clears", A_FLAG, 8'h20);
    endtask

    task automatic t_irq();
        global_ie = 1'b1;
        idle(1);
        check("R6 no enable", {7'd0, irq}, 8'h00);
        wr(A_IE, 8'h20);
        check("R6 enabled pending", {7'd0, irq}, 8'h01);
        global_ie = 1'b0;
        #1 check("R6 global off", {7'd0, irq}, 8'h00);
        global_ie = 1'b1;
        wr(A_FLAG, 8'h00);
        check("R6 flag cleared", {7'd0, irq}, 8'h00);
        wr(A_FLAG, 8'h80);
        check("R6 unenabled flag", {7'd0, irq}, 8'h00);
        wr(A_IE, 8'hA0);
        check("R6 sw interrupt", {7'd0, irq}, 8'h01);
        wr(A_FLAG, 8'h00);
        wr(A_IE, 8'h00);
    endtask

    task automatic t_collide();
        @(negedge clk);
        pad_in = 8'h3E;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        bus_addr = A_FLAG; bus_wdata = 8'h00; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd_check("R7 set wins", A_FLAG, 8'h20);
        wr(A_FLAG, 8'h00);
        rd_check("R7 later clear", A_FLAG, 8'h00);
    endtask

    task automatic t_loopback();
        pad_in = 8'h00;
        idle(4);
        wr(A_FLAG, 8'h00);
        wr(A_OUT, 8'h02);
        idle(4);
        rd_check("R9 out on input pin", A_FLAG, 8'h00);
        wr(A_DIR, 8'h02);
        idle(4);
        rd_check("R9 dir write sets", A_FLAG, 8'h02);
        rd_check("R8 readback", A_IN, 8'h02);
        wr(A_FLAG, 8'h00);
        wr(A_OUT, 8'h55);
        wr(A_DIR, 8'hF0);
        check("R8 pad_out", pad_out, 8'h55);
        check("R8 pad_oe", pad_oe, 8'hF0);
        idle(4);
        rd_check("R8 driven readback", A_IN, 8'h50);
        rd_check("R9 out/dir edges", A_FLAG, 8'h50);
    endtask

    task automatic t_map();
        wr(A_IN, 8'hFF);
        rd_check("R10 out kept", A_OUT, 8'h55);
        rd_check("R10 dir kept", A_DIR, 8'hF0);
        rd_check("R10 input unchanged", A_IN, 8'h50);
        rd_check("R10 addr6", 3'd6, 8'h00);
        rd_check("R10 addr7", 3'd7, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_rising();
        t_falling();
        t_level();
        t_sw();
        t_irq();
        t_collide();
        t_loopback();
        t_map();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule